// File: doc/BRIEF.md
# Trace Entry Writer with Time Stamps

The block takes captured trace records from a valid/ready stream and writes them, one entry per slot, into a circular region of trace memory. The region starts at a programmable base address. Its length is a number of equal buffers, either all of them or, with the half-region option, half of them. Each written word carries a 3-bit kind code above a payload. The kind code separates records from the four stamp types: elapsed-time, overflow, loss and sync.

Stamps are produced by one gap counter. The counter counts the cycles since the last entry and restarts whenever any entry is loaded. Before a record, the block writes an elapsed-time stamp if stamps are enabled and time has passed. It writes a loss stamp instead when records have been discarded since the last record. While the block is idle, a sync stamp is forced once the gap reaches a power-of-two interval chosen by a 3-bit field. An overflow stamp is written when the gap exceeds the stamp's counting range, unless single-stamp mode is set. At the end of the region the pointer either wraps to the start or stops the unit for good.

The input stream holds one record. In stall mode, `rec_ready` drops while that slot is full and cannot drain this cycle, so no record is lost. In discard mode, `rec_ready` stays high and a record that finds the slot full is dropped. The memory port follows valid/ready. An entry offered on it stays unchanged until the cycle in which `mem_ready` is high. With alternate mode set, successive accepted handshakes belong alternately to unit 0 and unit 1. This instance keeps only its own share and consumes the others silently. With alternate mode clear, unit 0 keeps every record.

Top module: `trace_writer`

## Requirements
- R1: After reset, `mem_valid` is 0, `wr_ptr` is 0, `wrapped` and `stopped` are 0, and `rec_ready` is 1.
- R2: Entry k of a run goes to address `cfg_base + wr_ptr` (modulo 2^ADDR_W). `mem_data[REC_W+2:REC_W]` holds the kind: 0 record, 1 elapsed, 2 overflow, 3 loss, 4 sync. The low REC_W bits hold the record, or the stamp count saturated at 2^TS_W-1 for elapsed and loss stamps, or zero for overflow and sync stamps.
- R3: While `mem_valid` is 1 and `mem_ready` is 0, `mem_addr` and `mem_data` hold their values and `mem_valid` stays 1.
- R4: With `cfg_stamp_en`=1, a held record is preceded by an elapsed stamp if at least one cycle passed since the last entry. Records that follow one another directly get no stamp.
- R5: With `cfg_stamp_en`=0, no elapsed or overflow stamps are written.
- R6: With stamps on and `cfg_single_stamp`=0, an idle unit writes an overflow stamp once the gap reaches 2^TS_W cycles. With `cfg_single_stamp`=1 it writes none.
- R7: An idle unit writes a sync stamp once the gap reaches 2^(SYNC_BASE+`cfg_sync_sel`) cycles. Sync takes priority over overflow.
- R8: With `cfg_stop_at_end`=0, the entry after the last slot goes to slot 0, and `wrapped` sets and stays set.
- R9: With `cfg_stop_at_end`=1, after the last slot is loaded `stopped` sets and stays set. No new entry is offered, and `rec_ready` is 1 with records dropped.
- R10: With `cfg_half_region`=1, the region holds NBUF*BUF_DEPTH/2 entries instead of NBUF*BUF_DEPTH.
- R11: With `cfg_drop_when_full`=0, `rec_ready` is 0 exactly when the held slot is full and not drained this cycle, and no record is lost.
- R12: With `cfg_drop_when_full`=1, `rec_ready` is always 1. A record that finds the slot full is discarded, and the next record is preceded by a loss stamp instead of an elapsed stamp.
- R13: With `cfg_alternate`=1, instance UNIT_ID keeps only the handshakes whose running parity equals UNIT_ID. With it clear, only unit 0 keeps records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_base | input | ADDR_W | Region base address |
| cfg_stop_at_end | input | 1 | 1: stop at end of region, 0: wrap |
| cfg_half_region | input | 1 | Use half the buffers |
| cfg_drop_when_full | input | 1 | 1: discard when full, 0: back-pressure |
| cfg_stamp_en | input | 1 | Enable elapsed/overflow stamps |
| cfg_single_stamp | input | 1 | Suppress overflow stamps |
| cfg_sync_sel | input | 3 | Sync interval exponent offset |
| cfg_alternate | input | 1 | Share records between two units |
| rec_valid | input | 1 | Record offered |
| rec_ready | output | 1 | Record taken this cycle |
| rec_data | input | REC_W | Record payload |
| mem_valid | output | 1 | Entry offered to memory |
| mem_ready | input | 1 | Memory takes the entry |
| mem_addr | output | ADDR_W | Entry address |
| mem_data | output | REC_W+3 | Kind code and payload |
| wr_ptr | output | log2(NBUF*BUF_DEPTH)+1 | Slot of the next entry |
| wrapped | output | 1 | Region has wrapped at least once |
| stopped | output | 1 | Unit halted at end of region |

## Verification
A wrong gap count shows at the ports on the next stamp. The stamp payload is off, or a sync or overflow stamp appears one cycle early or late, so an idle stretch of a few dozen cycles exposes it. A corrupted pointer or end-of-region test shows in `mem_addr` on the very next entry, or in `wrapped` and `stopped` within one region length. A stuck loss flag or held-record slot shows as an extra or missing loss stamp, or as `rec_ready` differing in the same cycle. For these reasons the outputs are compared with an independent behavioural model on every clock.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    ENT_REC     = 3'd0,
    ENT_ELAPSED = 3'd1,
    ENT_OVF     = 3'd2,
    ENT_LOSS    = 3'd3,
    ENT_SYNC    = 3'd4
  } ent_kind_e;
endpackage

// File: rtl/tw_intake.sv
// One-record holding slot with back-pressure or discard, unit sharing and loss flag.
module tw_intake #(
  parameter int REC_W   = 16,
  parameter int UNIT_ID = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_valid,
  input  logic [REC_W-1:0] rec_data,
  output logic             rec_ready,
  input  logic             cfg_alternate,
  input  logic             cfg_drop,
  input  logic             stopped,
  input  logic             take_rec,
  input  logic             clr_loss,
  output logic             hold_v,
  output logic [REC_W-1:0] hold_data,
  output logic             loss_flag
);
  localparam logic UNIT_BIT = 1'(UNIT_ID);
  localparam logic HOME     = (UNIT_ID == 0);

  logic turn, mine, room, hs, keep, lose;

  assign mine      = cfg_alternate ? (turn == UNIT_BIT) : HOME;
  assign room      = !hold_v || take_rec;
  assign rec_ready = stopped || !mine || cfg_drop || room;
  assign hs        = rec_valid && rec_ready;
  assign keep      = hs && mine && !stopped && room;
  assign lose      = hs && mine && !stopped && !room;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      turn      <= 1'b0;
      hold_v    <= 1'b0;
      hold_data <= '0;
      loss_flag <= 1'b0;
    end else begin
      if (hs) turn <= !turn;
      if (keep) begin
        hold_v    <= 1'b1;
        hold_data <= rec_data;
      end else if (take_rec) begin
        hold_v <= 1'b0;
      end
      if (lose) loss_flag <= 1'b1;
      else if (clr_loss) loss_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tw_gap_timer.sv
// Cycles since the last loaded entry; derives sync/overflow due and stamp value.
module tw_gap_timer #(
  parameter int TS_W      = 4,
  parameter int SYNC_BASE = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wrote,
  input  logic [2:0]      cfg_sync_sel,
  output logic            sync_due,
  output logic            ovf_due,
  output logic            gap_nz,
  output logic [TS_W-1:0] stamp_val
);
  localparam int CNT_W = SYNC_BASE + 8;
  localparam logic [CNT_W-1:0] TS_MAX = CNT_W'((1 << TS_W) - 1);

  logic [CNT_W-1:0] gap, sync_lim;

  assign sync_lim  = CNT_W'(1) << (SYNC_BASE + int'(cfg_sync_sel));
  assign sync_due  = gap >= sync_lim;
  assign ovf_due   = |gap[CNT_W-1:TS_W];
  assign gap_nz    = |gap;
  assign stamp_val = (gap >= TS_MAX) ? '1 : gap[TS_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)      gap <= '0;
    else if (wrote)  gap <= '0;
    else if (~&gap)  gap <= gap + 1'b1;
  end
endmodule

// File: rtl/tw_region_ptr.sv
// Slot pointer with full/half region length, wrap or stop at the end.
module tw_region_ptr #(
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  logic                     cfg_half,
  input  logic                     cfg_stop,
  output logic [$clog2(DEPTH):0]   ptr,
  output logic                     wrapped,
  output logic                     stopped
);
  localparam int PTR_W = $clog2(DEPTH) + 1;
  localparam logic [PTR_W-1:0] FULL_LIM = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] HALF_LIM = PTR_W'(DEPTH / 2);

  logic [PTR_W-1:0] lim, nxt;

  assign lim = cfg_half ? HALF_LIM : FULL_LIM;
  assign nxt = ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      wrapped <= 1'b0;
      stopped <= 1'b0;
    end else if (adv) begin
      if (nxt == lim) begin
        if (cfg_stop) begin
          ptr     <= nxt;
          stopped <= 1'b1;
        end else begin
          ptr     <= '0;
          wrapped <= 1'b1;
        end
      end else begin
        ptr <= nxt;
      end
    end
  end
endmodule

// File: rtl/trace_writer.sv
module trace_writer
  import tw_pkg::*;
#(
  parameter int REC_W     = 16,
  parameter int ADDR_W    = 16,
  parameter int NBUF      = 8,
  parameter int BUF_DEPTH = 4,
  parameter int TS_W      = 4,
  parameter int SYNC_BASE = 3,
  parameter int UNIT_ID   = 0
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [ADDR_W-1:0]                  cfg_base,
  input  logic                               cfg_stop_at_end,
  input  logic                               cfg_half_region,
  input  logic                               cfg_drop_when_full,
  input  logic                               cfg_stamp_en,
  input  logic                               cfg_single_stamp,
  input  logic [2:0]                         cfg_sync_sel,
  input  logic                               cfg_alternate,
  input  logic                               rec_valid,
  output logic                               rec_ready,
  input  logic [REC_W-1:0]                   rec_data,
  output logic                               mem_valid,
  input  logic                               mem_ready,
  output logic [ADDR_W-1:0]                  mem_addr,
  output logic [REC_W+2:0]                   mem_data,
  output logic [$clog2(NBUF*BUF_DEPTH):0]    wr_ptr,
  output logic                               wrapped,
  output logic                               stopped
);
  localparam int DEPTH = NBUF * BUF_DEPTH;
  localparam int PTR_W = $clog2(DEPTH) + 1;
  localparam int ENT_W = REC_W + KIND_W;

  logic             hold_v, loss_flag, take_rec, clr_loss, load, out_free;
  logic [REC_W-1:0] hold_data, payload;
  logic             sync_due, ovf_due, gap_nz;
  logic [TS_W-1:0]  stamp_val;
  ent_kind_e        kind;
  logic             out_v;
  logic [ADDR_W-1:0] out_addr;
  logic [ENT_W-1:0] out_data;

  tw_intake #(.REC_W(REC_W), .UNIT_ID(UNIT_ID)) u_intake (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_data(rec_data),
    .rec_ready(rec_ready), .cfg_alternate(cfg_alternate), .cfg_drop(cfg_drop_when_full),
    .stopped(stopped), .take_rec(take_rec), .clr_loss(clr_loss),
    .hold_v(hold_v), .hold_data(hold_data), .loss_flag(loss_flag)
  );

  tw_gap_timer #(.TS_W(TS_W), .SYNC_BASE(SYNC_BASE)) u_timer (
    .clk(clk), .rst_n(rst_n), .wrote(load), .cfg_sync_sel(cfg_sync_sel),
    .sync_due(sync_due), .ovf_due(ovf_due), .gap_nz(gap_nz), .stamp_val(stamp_val)
  );

  tw_region_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(load), .cfg_half(cfg_half_region),
    .cfg_stop(cfg_stop_at_end), .ptr(wr_ptr), .wrapped(wrapped), .stopped(stopped)
  );

  assign out_free = !out_v || mem_ready;

  // Entry selection: loss, elapsed, record for a held record; else sync, then overflow.
  always_comb begin
    load     = 1'b0;
    kind     = ENT_REC;
    payload  = '0;
    take_rec = 1'b0;
    clr_loss = 1'b0;
    if (out_free && !stopped) begin
      if (hold_v && loss_flag) begin
        load = 1'b1; kind = ENT_LOSS; payload = REC_W'(stamp_val); clr_loss = 1'b1;
      end else if (hold_v && cfg_stamp_en && gap_nz) begin
        load = 1'b1; kind = ENT_ELAPSED; payload = REC_W'(stamp_val);
      end else if (hold_v) begin
        load = 1'b1; kind = ENT_REC; payload = hold_data; take_rec = 1'b1;
      end else if (sync_due) begin
        load = 1'b1; kind = ENT_SYNC;
      end else if (cfg_stamp_en && !cfg_single_stamp && ovf_due) begin
        load = 1'b1; kind = ENT_OVF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v    <= 1'b0;
      out_addr <= '0;
      out_data <= '0;
    end else if (load) begin
      out_v    <= 1'b1;
      out_addr <= cfg_base + ADDR_W'(wr_ptr);
      out_data <= {kind, payload};
    end else if (mem_ready) begin
      out_v <= 1'b0;
    end
  end

  assign mem_valid = out_v;
  assign mem_addr  = out_addr;
  assign mem_data  = out_data;
endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
  parameter int ADDR_W = 16,
  parameter int ENT_W  = 19,
  parameter int PTR_W  = 6,
  parameter int DEPTH  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ENT_W-1:0]  mem_data,
  input logic              rec_ready,
  input logic              cfg_drop,
  input logic              cfg_half,
  input logic [PTR_W-1:0]  wr_ptr,
  input logic              wrapped,
  input logic              stopped
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !mem_valid && wr_ptr == '0 && !wrapped && !stopped);

  // R2
  kind_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_data[ENT_W-1 -: 3] <= 3'd4);

  // R3
  hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_data) && $stable(mem_addr));

  // R8
  wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped |=> wrapped);

  // R9
  stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> stopped);

  // R9
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopped && (!mem_valid || mem_ready) |=> !mem_valid);

  // R10
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stopped |-> int'(wr_ptr) < (cfg_half ? DEPTH / 2 : DEPTH));

  // R12
  drop_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_drop |-> rec_ready);
endmodule

bind trace_writer tw_checker #(
  .ADDR_W(ADDR_W), .ENT_W(ENT_W), .PTR_W(PTR_W), .DEPTH(DEPTH)
) u_tw_checker (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .rec_ready(rec_ready),
  .cfg_drop(cfg_drop_when_full), .cfg_half(cfg_half_region), .wr_ptr(wr_ptr),
  .wrapped(wrapped), .stopped(stopped)
);

// File: tb/test_trace_writer.sv
module test_trace_writer;
  // 1 ps time units: half period 2500 gives 200 MHz.
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_base = 16'h0100;
  logic        cfg_stop_at_end = 1'b0, cfg_half_region = 1'b0, cfg_drop_when_full = 1'b0;
  logic        cfg_stamp_en = 1'b1, cfg_single_stamp = 1'b0, cfg_alternate = 1'b0;
  logic [2:0]  cfg_sync_sel = 3'd7;
  logic        rec_valid = 1'b0, mem_ready = 1'b1;
  logic [15:0] rec_data = '0;
  logic        rec_ready, mem_valid, wrapped, stopped;
  logic [15:0] mem_addr;
  logic [18:0] mem_data;
  logic [5:0]  wr_ptr;

  trace_writer i_trace_writer (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_stop_at_end(cfg_stop_at_end),
    .cfg_half_region(cfg_half_region), .cfg_drop_when_full(cfg_drop_when_full),
    .cfg_stamp_en(cfg_stamp_en), .cfg_single_stamp(cfg_single_stamp),
    .cfg_sync_sel(cfg_sync_sel), .cfg_alternate(cfg_alternate),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .wr_ptr(wr_ptr), .wrapped(wrapped), .stopped(stopped)
  );

  always #2500 clk = ~clk;

  int    n_chk = 0, n_fail = 0;
  string req = "R1";
  bit    chk_en = 0, rnd_ready = 0, done = 0;

  // Behavioural reference: kinds 0 rec,1 elapsed,2 overflow,3 loss,4 sync; -1 none.
  int m_out_v, m_out_addr, m_out_data, m_hold_v, m_hold_d, m_loss, m_turn;
  int m_gap, m_ptr, m_wrap, m_stop;

  function automatic int region_len();
    return cfg_half_region ? 16 : 32;
  endfunction

  function automatic int stamp_of(int g);
    return (g >= 15) ? 15 : g;
  endfunction

  function automatic int pick_kind();
    if (!((m_out_v == 0) || mem_ready) || m_stop != 0) return -1;
    if (m_hold_v != 0 && m_loss != 0) return 3;
    if (m_hold_v != 0 && cfg_stamp_en && m_gap > 0) return 1;
    if (m_hold_v != 0) return 0;
    if (m_gap >= (1 << (3 + int'(cfg_sync_sel)))) return 4;
    if (cfg_stamp_en && !cfg_single_stamp && m_gap >= 16) return 2;
    return -1;
  endfunction

  function automatic int owned();
    return cfg_alternate ? (m_turn == 0 ? 1 : 0) : 1;
  endfunction

  function automatic int model_ready();
    int room;
    room = (m_hold_v == 0 || pick_kind() == 0) ? 1 : 0;
    return (m_stop != 0 || owned() == 0 || cfg_drop_when_full || room != 0) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out_v = 0; m_out_addr = 0; m_out_data = 0; m_hold_v = 0; m_hold_d = 0;
      m_loss = 0; m_turn = 0; m_gap = 0; m_ptr = 0; m_wrap = 0; m_stop = 0;
    end else begin
      int k, pay, hs, mine, room, stop_now;
      k    = pick_kind();
      mine = owned();
      room = (m_hold_v == 0 || k == 0) ? 1 : 0;
      hs   = (rec_valid && model_ready() != 0) ? 1 : 0;
      stop_now = m_stop;
      case (k)
        0: pay = m_hold_d;
        1, 3: pay = stamp_of(m_gap);
        default: pay = 0;
      endcase
      if (k >= 0) begin
        m_out_v = 1;
        m_out_addr = (int'(cfg_base) + m_ptr) % 65536;
        m_out_data = (k << 16) | pay;
        m_gap = 0;
        if (m_ptr + 1 == region_len()) begin
          if (cfg_stop_at_end) begin m_ptr = m_ptr + 1; m_stop = 1; end
          else begin m_ptr = 0; m_wrap = 1; end
        end else m_ptr = m_ptr + 1;
      end else begin
        if (mem_ready) m_out_v = 0;
        if (m_gap < 2047) m_gap = m_gap + 1;
      end
      if (k == 0) m_hold_v = 0;
      if (k == 3) m_loss = 0;
      if (hs != 0 && mine != 0 && stop_now == 0) begin
        if (room != 0) begin m_hold_v = 1; m_hold_d = int'(rec_data); end
        else m_loss = 1;
      end
      if (hs != 0) m_turn = 1 - m_turn;
    end
  end

  task automatic check(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1000;
    if (chk_en && rst_n) begin
      check("mem_valid", int'(mem_valid), m_out_v);
      if (m_out_v != 0) begin
        check("mem_addr", int'(mem_addr), m_out_addr);
        check("mem_data", int'(mem_data), m_out_data);
      end
      check("rec_ready", int'(rec_ready), model_ready());
      check("wr_ptr", int'(wr_ptr), m_ptr);
      check("wrapped", int'(wrapped), m_wrap);
      check("stopped", int'(stopped), m_stop);
    end
  end

  always @(negedge clk) if (rnd_ready) mem_ready = 1'($urandom % 2);

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rec_valid = 1'b0;
    idle(2);
    rst_n = 1'b1;
    chk_en = 1;
  endtask

  // Offer n records back to back starting from d0; call right after a falling edge.
  task automatic burst(int n, int d0);
    for (int i = 0; i < n; i++) begin
      rec_valid = 1'b1;
      rec_data = 16'(d0 + i);
      #2000;
      while (!rec_ready) begin @(negedge clk); #2000; end
      @(negedge clk);
    end
    rec_valid = 1'b0;
  endtask

  task automatic defaults();
    cfg_base = 16'h0100; cfg_stop_at_end = 0; cfg_half_region = 0; cfg_drop_when_full = 0;
    cfg_stamp_en = 1; cfg_single_stamp = 0; cfg_sync_sel = 3'd7; cfg_alternate = 0;
    mem_ready = 1; rnd_ready = 0;
  endtask

  initial begin
    idle(1);
    // R1: reset state
    req = "R1"; defaults(); do_reset(); idle(4);

    // R2, R4: format, addressing, elapsed stamps, back-to-back records
    req = "R2,R4"; defaults(); cfg_single_stamp = 1; do_reset();
    burst(1, 16'h00A1); idle(5);
    burst(1, 16'h00A2); idle(20);
    burst(4, 16'h00B0); idle(6);

    // R3, R11: random memory back-pressure with a stalling source
    req = "R3,R11"; defaults(); do_reset();
    rnd_ready = 1; burst(12, 16'h0C00); idle(30); rnd_ready = 0; mem_ready = 1; idle(4);

    // R5: stamps disabled
    req = "R5"; defaults(); cfg_stamp_en = 0; do_reset();
    burst(1, 16'h0051); idle(10); burst(2, 16'h0052); idle(60);

    // R6: overflow stamps, then single-stamp mode
    req = "R6"; defaults(); do_reset();
    idle(60);
    cfg_single_stamp = 1; idle(60);
    burst(1, 16'h0061); idle(4);

    // R7: forced sync stamps at two intervals
    req = "R7"; defaults(); cfg_sync_sel = 3'd0; do_reset();
    idle(40);
    cfg_sync_sel = 3'd2; idle(80);

    // R8: wrap at end of region
    req = "R8"; defaults(); cfg_stamp_en = 0; cfg_base = 16'hFFF0; do_reset();
    burst(40, 16'h0800); idle(4);

    // R9: stop at end of region
    req = "R9"; defaults(); cfg_stamp_en = 0; cfg_stop_at_end = 1; do_reset();
    burst(40, 16'h0900); idle(10);

    // R10: half region
    req = "R10"; defaults(); cfg_stamp_en = 0; cfg_stop_at_end = 1; cfg_half_region = 1;
    do_reset();
    burst(24, 16'h0A00); idle(6);

    // R12: discard when full, loss stamp
    req = "R12"; defaults(); cfg_drop_when_full = 1; do_reset();
    mem_ready = 0; burst(5, 16'h0D00); idle(2);
    mem_ready = 1; idle(3); burst(3, 16'h0D10); idle(10);

    // R13: alternate sharing, then unit 0 keeps all
    req = "R13"; defaults(); cfg_stamp_en = 0; cfg_alternate = 1; do_reset();
    burst(8, 16'h0E00); idle(4);
    cfg_alternate = 0; burst(4, 16'h0E10); idle(6);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule